// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block sequences external bus cycles for an 8-bit controller core whose memory and I/O sit outside the chip on a shared address/data port. The core presents one request at a time. A request carries a 16-bit address, a direction, a space select (data memory or program/I/O) and, for writes, a byte. The block puts the upper address byte on a dedicated output. It then uses one shared 8-bit port twice: first for the lower address byte, framed by a one-clock low address strobe, and then for the data byte, framed by a separate low data strobe.

A read leaves the shared port undriven while the data strobe is low. It captures the input byte on the clock edge where the data strobe returns high. A write drives its byte from the clock after the address strobe until the cycle ends. Its data-strobe pulse is shorter than a read's. An extended-timing input, sampled when the request is accepted, lengthens the data-strobe phase by two clocks. When the cycle ends, a one-clock done pulse is raised, and the read byte is presented alongside it.

Top module: `muxbus_seq`

## Requirements
- R1: A request (req_valid high) is accepted only at a clock edge where busy is low. busy is high from the next clock until the end of the recovery clock, so a cycle lasts 3 + S clocks, where S is the strobe length.
- R2: In the first clock of a cycle, as_n is low for exactly that one clock. ad_out carries address bits 7:0 with ad_oe high, and addr_hi carries address bits 15:8 for the whole cycle.
- R3: A turnaround clock with both strobes high follows the address strobe. ds_n falls only while as_n is high and was high in the previous clock.
- R4: A read holds ds_n low for S=3 clocks (S=5 with extended timing), with ad_oe low for all of them. The read byte is ad_in as sampled at the clock edge where ds_n returns high.
- R5: A write holds ds_n low for S=2 clocks (S=4 with extended timing). ad_out carries the write byte with ad_oe high from the turnaround clock through the recovery clock.
- R6: rd_wr_n (1 = read, 0 = write) and dm_n (0 = data-memory space) hold their request values from the address-strobe clock through the recovery clock. Both are 1 while idle.
- R7: ext_timing is sampled only when a request is accepted. Changing it later in the cycle has no effect on that cycle.
- R8: done is high for exactly one clock, the recovery clock after ds_n rises. rdata then holds the captured read byte. A write cycle leaves rdata unchanged.
- R9: At least two clocks with both strobes high separate the rise of ds_n from the next fall of as_n, even with back-to-back requests.
- R10: Requests raised while busy is high are ignored. The address, direction and length of the running cycle do not change, and no cycle follows unless a request is present when idle.
- R11: After reset, as_n, ds_n, rd_wr_n, dm_n and ad_oe are 1, and busy, done and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dspace | input | 1 | 1 = data-memory space |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| ext_timing | input | 1 | Stretch the data-strobe phase by two clocks |
| ad_in | input | 8 | Shared port, input side |
| ad_out | output | 8 | Shared port, output side |
| ad_oe | output | 1 | Shared port drive enable |
| addr_hi | output | 8 | Upper address byte |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rd_wr_n | output | 1 | Direction, high for read |
| dm_n | output | 1 | Data-memory select, active low |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Last captured read byte |

## Verification
Counting from the accepting edge, the bench expects as_n low in clock 0 and the turnaround in clock 1. It expects ds_n low in clocks 2 to S+1, done with rdata in clock S+2, and idle strobes in clock S+3. It samples every one of these clocks at the falling edge and compares it against a per-clock expectation computed from direction and the latched extended-timing bit. The bench places the memory byte on ad_in only in clock S+1 and drives its complement in every other clock. A capture on any other edge therefore shows up in rdata at clock S+2.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_TURN  = 3'd2,
        ST_STRB  = 3'd3,
        ST_RECOV = 3'd4
    } bus_state_e;

endpackage

// File: rtl/muxbus_fsm.sv
module muxbus_fsm
    import muxbus_pkg::*;
#(
    parameter int RD_STRB   = 3,
    parameter int WR_STRB   = 2,
    parameter int EXT_EXTRA = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_ext,
    output bus_state_e state,
    output logic       accept,
    output logic       capture,
    output logic       as_n,
    output logic       ds_n,
    output logic       busy,
    output logic       done
);

    localparam int LEN_MAX = RD_STRB + EXT_EXTRA;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    typedef struct packed {
        bus_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic [CNT_W-1:0] len_d;

    always_comb begin
        len_d   = req_write ? CNT_W'(WR_STRB) : CNT_W'(RD_STRB);
        if (req_ext) len_d = len_d + CNT_W'(EXT_EXTRA);
        nxt_d   = cur_q;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept    = 1'b1;
                    nxt_d.st  = ST_ADDR;
                    nxt_d.cnt = len_d - CNT_W'(1);
                end
            end
            ST_ADDR: nxt_d.st = ST_TURN;
            ST_TURN: nxt_d.st = ST_STRB;
            ST_STRB: begin
                if (cur_q.cnt == '0) begin
                    capture  = 1'b1;
                    nxt_d.st = ST_RECOV;
                end else begin
                    nxt_d.cnt = cur_q.cnt - CNT_W'(1);
                end
            end
            ST_RECOV: nxt_d.st = ST_IDLE;
            default:  nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st  <= ST_IDLE;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state = cur_q.st;
    assign as_n  = (cur_q.st != ST_ADDR);
    assign ds_n  = (cur_q.st != ST_STRB);
    assign busy  = (cur_q.st != ST_IDLE);
    assign done  = (cur_q.st == ST_RECOV);

    // Strobe run-length trackers feeding the timing properties below
    logic [1:0]       ds_hi_run_q;
    logic [CNT_W-1:0] ds_lo_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_hi_run_q <= 2'd3;
            ds_lo_run_q <= '0;
        end else begin
            if (ds_n) begin
                ds_hi_run_q <= (ds_hi_run_q == 2'd3) ? 2'd3 : ds_hi_run_q + 2'd1;
                ds_lo_run_q <= '0;
            end else begin
                ds_hi_run_q <= 2'd0;
                ds_lo_run_q <= (ds_lo_run_q == CNT_W'(LEN_MAX)) ? ds_lo_run_q
                                                                : ds_lo_run_q + CNT_W'(1);
            end
        end
    end

    p_as_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> as_n);

    p_ds_after_as_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n) |-> (as_n && $past(as_n)));

    p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n) |-> (ds_lo_run_q == CNT_W'(RD_STRB) || ds_lo_run_q == CNT_W'(WR_STRB) ||
                         ds_lo_run_q == CNT_W'(RD_STRB + EXT_EXTRA) ||
                         ds_lo_run_q == CNT_W'(WR_STRB + EXT_EXTRA)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_ds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n) |-> done);

    p_strobe_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n) |-> (ds_hi_run_q >= 2'd2));

endmodule

// File: rtl/muxbus_datapath.sv
module muxbus_datapath
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_dspace,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              rd_wr_n,
    output logic              dm_n,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              dspace;
        logic [DATA_W-1:0] rdata;
    } dp_t;

    dp_t cur_q, nxt_d;
    logic active;
    logic data_phase;

    always_comb begin
        nxt_d = cur_q;
        if (accept) begin
            nxt_d.addr   = req_addr;
            nxt_d.wdata  = req_wdata;
            nxt_d.write  = req_write;
            nxt_d.dspace = req_dspace;
        end
        if (capture && !cur_q.write) begin
            nxt_d.rdata = ad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign active     = (state != ST_IDLE);
    assign data_phase = (state == ST_TURN) || (state == ST_STRB) || (state == ST_RECOV);

    assign addr_hi = cur_q.addr[ADDR_W-1:DATA_W];
    assign ad_out  = (cur_q.write && data_phase) ? cur_q.wdata : cur_q.addr[DATA_W-1:0];
    assign ad_oe   = !((state == ST_STRB) && !cur_q.write);
    assign rd_wr_n = active ? !cur_q.write : 1'b1;
    assign dm_n    = active ? !cur_q.dspace : 1'b1;
    assign rdata   = cur_q.rdata;

    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN || state == ST_STRB || state == ST_RECOV) |->
            ($stable(rd_wr_n) && $stable(dm_n)));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_ADDR) |-> $stable(addr_hi));

    p_rdata_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !rd_wr_n) |=> $stable(rdata));

endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int RD_STRB   = 3,
    parameter int WR_STRB   = 2,
    parameter int EXT_EXTRA = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_dspace,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ext_timing,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic              as_n,
    output logic              ds_n,
    output logic              rd_wr_n,
    output logic              dm_n,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    bus_state_e state;
    logic       accept;
    logic       capture;

    muxbus_fsm #(
        .RD_STRB  (RD_STRB),
        .WR_STRB  (WR_STRB),
        .EXT_EXTRA(EXT_EXTRA)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ext  (ext_timing),
        .state    (state),
        .accept   (accept),
        .capture  (capture),
        .as_n     (as_n),
        .ds_n     (ds_n),
        .busy     (busy),
        .done     (done)
    );

    muxbus_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_dspace(req_dspace),
        .ad_in     (ad_in),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .rd_wr_n   (rd_wr_n),
        .dm_n      (dm_n),
        .rdata     (rdata)
    );

    p_read_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rd_wr_n) |-> !ad_oe);

    p_write_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && !rd_wr_n) |-> ad_oe);

    p_accept_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/muxbus_seq_bench.sv
module muxbus_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_dspace = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ext_timing = 1'b0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  addr_hi;
    logic        as_n, ds_n, rd_wr_n, dm_n, busy, done;
    logic [7:0]  rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_rdata = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    muxbus_seq u_muxbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_dspace(req_dspace), .req_addr(req_addr), .req_wdata(req_wdata),
        .ext_timing(ext_timing), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .as_n(as_n), .ds_n(ds_n), .rd_wr_n(rd_wr_n), .dm_n(dm_n),
        .busy(busy), .done(done), .rdata(rdata)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int strb_len(input logic wr, input logic ext);
        return (wr ? 2 : 3) + (ext ? 2 : 0);
    endfunction

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Called at a falling edge with the block idle; returns at the falling
    // edge of the first idle clock after the cycle.
    task automatic run_txn(input logic wr, input logic dsp, input logic ext,
                           input logic [15:0] a, input logic [7:0] wd,
                           input logic poke, input logic flip_ext);
        int n;
        string tr;
        n = strb_len(wr, ext);
        tr = flip_ext ? "R7" : (wr ? "R5" : "R4");
        req_valid = 1'b1; req_write = wr; req_dspace = dsp;
        req_addr = a; req_wdata = wd; ext_timing = ext;
        for (int i = 0; i <= n + 3; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req_valid = 1'b0;
                if (flip_ext) ext_timing = ~ext;
            end
            if (poke && i == 2) begin
                req_valid = 1'b1; req_addr = ~a; req_write = ~wr; ext_timing = ~ext;
            end
            if (poke && i == 3) req_valid = 1'b0;
            ad_in = (i == n + 1) ? mem_val(a) : ~mem_val(a);
            #1;
            chk(busy, (i <= n + 2), poke ? "R10" : "R1", "busy");
            chk(as_n, (i != 0), "R2", "as_n");
            chk(ds_n, !(i >= 2 && i <= n + 1), i == 1 ? "R3" : tr, "ds_n");
            chk(done, (i == n + 2), "R8", "done");
            chk(rd_wr_n, (i <= n + 2) ? !wr : 1'b1, "R6", "rd_wr_n");
            chk(dm_n, (i <= n + 2) ? !dsp : 1'b1, "R6", "dm_n");
            chk(ad_oe, !(i >= 2 && i <= n + 1 && !wr), wr ? "R5" : "R4", "ad_oe");
            if (i <= n + 2) chk(addr_hi, a[15:8], poke ? "R10" : "R2", "addr_hi");
            if (i == 0) chk(ad_out, a[7:0], "R2", "ad_out address");
            if (wr && i >= 1 && i <= n + 2) chk(ad_out, wd, "R5", "ad_out write data");
            if (i == n + 3) chk({as_n, ds_n}, 2'b11, "R9", "idle strobes after cycle");
            if (i == n + 2) begin
                if (!wr) exp_rdata = mem_val(a);
                chk(rdata, exp_rdata, wr ? "R8" : "R4", "rdata");
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        #(CLK_PERIOD * 3);
        @(negedge clk);
        // R11: reset state
        chk({as_n, ds_n, rd_wr_n, dm_n, ad_oe}, 5'h1F, "R11", "strobes in reset");
        chk({busy, done}, 2'b00, "R11", "busy/done in reset");
        chk(rdata, 8'h00, "R11", "rdata in reset");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(busy, 1'b0, "R1", "idle without request");

        // Directed corners
        run_txn(1'b0, 1'b1, 1'b0, 16'h12C4, 8'h00, 1'b0, 1'b0); // basic read
        run_txn(1'b1, 1'b0, 1'b0, 16'hA53C, 8'h9E, 1'b0, 1'b0); // basic write
        run_txn(1'b0, 1'b0, 1'b1, 16'h0FF0, 8'h00, 1'b0, 1'b0); // extended read
        run_txn(1'b1, 1'b1, 1'b1, 16'hFFFF, 8'h01, 1'b0, 1'b0); // extended write
        run_txn(1'b0, 1'b1, 1'b0, 16'h3377, 8'h00, 1'b0, 1'b1); // R7 ext flip
        run_txn(1'b1, 1'b0, 1'b1, 16'h4411, 8'h66, 1'b0, 1'b1); // R7 ext flip
        run_txn(1'b0, 1'b0, 1'b1, 16'h8001, 8'h00, 1'b1, 1'b0); // R10 poke
        run_txn(1'b1, 1'b1, 1'b0, 16'h0000, 8'hFF, 1'b1, 1'b0); // R10 poke
        // R10: nothing follows the poked cycle
        @(negedge clk); #1;
        chk(busy, 1'b0, "R10", "no cycle after ignored request");

        // Constrained random traffic
        for (int k = 0; k < 60; k++) begin
            logic [31:0] r;
            r = $urandom;
            run_txn(r[0], r[1], r[2], $urandom, $urandom, r[3] & r[4], r[5] & r[6]);
            for (int g = 0; g < int'(r[9:8]); g++) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule